// File: doc/BRIEF.md
# PCI Bridge Data-Parity Error Signaller

This block sits beside the datapath of a two-port PCI-to-PCI bridge. It decides when the bridge drives its secondary-side data-parity-error line low and when it raises a system error on the primary side. Once per data phase the datapath presents an event. The event gives:

- the transaction kind;
- the forwarding direction;
- the bus on which the error showed up;
- whether the bridge's own parity checker caught it;
- whether another agent's PERR# was sampled asserted on that bus.

The configuration enables arrive as plain inputs.

The secondary error line is a one-clock low pulse that follows the faulty data phase by two clocks. The primary system-error line is a one-clock low pulse on the clock after the event. Each such pulse also sets a sticky status flag, which a write-one-to-clear strobe resets.

Encodings used on the event inputs:

- Transaction kind: 00 read, 01 posted write, 10 delayed write, 11 reserved.
- Direction: 0 downstream, 1 upstream.
- Bus: 0 primary, 1 secondary.

Top module: `pci_bridge_err_reporter`

## Requirements
- R1: During and right after reset, `s_perr_n` and `p_serr_n` are 1 and `serr_status` is 0.
- R2: A qualifying secondary-error event sampled at rising edge t drives `s_perr_n` low from edge t+1 until edge t+2, and no longer, unless a further event qualifies.
- R3: A downstream read (kind 00, dir 0) drives `s_perr_n` low when bus=1, own-detect=1 and `cfg_sec_perr_en`=1. With bus=0 it leaves `s_perr_n` high.
- R4: An upstream posted write (kind 01, dir 1) drives `s_perr_n` low when bus=1, own-detect=1 and `cfg_sec_perr_en`=1. Downstream posted writes and upstream reads never drive it low.
- R5: An upstream delayed write (kind 10, dir 1) drives `s_perr_n` low in either of two cases:
  - bus=1, own-detect=1 and `cfg_sec_perr_en`=1;
  - bus=0, PERR#-seen=1, and both `cfg_pri_perr_en` and `cfg_sec_perr_en` are 1.
- R6: A downstream delayed write (kind 10, dir 0) never drives `s_perr_n` low.
- R7: With `cfg_sec_perr_en`=0, no event drives `s_perr_n` low.
- R8: A posted write drives `p_serr_n` low for the one clock after the sampling edge when all of these hold:
  - PERR#-seen=1 and own-detect=0;
  - either dir=1 with bus=0, or dir=0 with bus=1;
  - all enables are set.
- R9: `p_serr_n` stays high unless `cfg_pri_perr_en`, `cfg_sec_perr_en` and `cfg_serr_en` are all 1. Reads and delayed writes never drive it low.
- R10: `serr_status` becomes 1 on the edge where `p_serr_n` goes low and holds there. A `serr_clr` pulse clears it at the next edge unless a new system error is signalled in the same cycle, in which case the flag stays 1.
- R11: Events with `evt_valid`=0 or kind 11 change neither output nor the status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Data-phase event present |
| evt_kind | input | 2 | Transaction kind (00 rd, 01 posted wr, 10 delayed wr, 11 reserved) |
| evt_dir | input | 1 | 0 downstream, 1 upstream |
| evt_bus | input | 1 | Bus where the error was seen: 0 primary, 1 secondary |
| evt_own_det | input | 1 | Bridge's own checker found bad parity |
| evt_perr_seen | input | 1 | PERR# from another agent sampled asserted |
| cfg_pri_perr_en | input | 1 | Primary parity-error response enable |
| cfg_sec_perr_en | input | 1 | Secondary parity-error response enable |
| cfg_serr_en | input | 1 | System-error enable |
| serr_clr | input | 1 | Write-one-to-clear strobe for the status flag |
| s_perr_n | output | 1 | Secondary data-parity-error line, active low |
| p_serr_n | output | 1 | Primary system-error line, active low |
| serr_status | output | 1 | Sticky "system error signalled" flag |

## Verification
Two functions can meet in one cycle:
- the status flag's clear strobe and a fresh system-error event;
- the secondary-error pulse of an older event and the system-error pulse of a newer one.

The random stream drives `serr_clr` independently of the events, so clears land on qualifying posted writes. Directed steps also place a clear exactly on a qualifying event, where the flag must stay set. Back-to-back events, with a two-stage reference pipeline in the bench, judge both outputs of overlapping events in every cycle.

// File: rtl/pci_perr_pkg.sv
package pci_perr_pkg;

    typedef enum logic [1:0] {
        XK_READ   = 2'b00,
        XK_PWRITE = 2'b01,
        XK_DWRITE = 2'b10,
        XK_RSVD   = 2'b11
    } xact_kind_e;

    typedef struct packed {
        logic serr_n;
        logic status;
    } top_state_t;

endpackage

// File: rtl/perr_event_decode.sv
module perr_event_decode
    import pci_perr_pkg::*;
(
    input  logic       evt_valid,
    input  logic [1:0] evt_kind,
    input  logic       evt_dir,
    input  logic       evt_bus,
    input  logic       evt_own_det,
    input  logic       evt_perr_seen,
    input  logic       cfg_pri_perr_en,
    input  logic       cfg_sec_perr_en,
    input  logic       cfg_serr_en,
    output logic       sperr_hit,
    output logic       serr_hit
);

    logic is_rd, is_pw, is_dw;
    logic sec_own;
    logic both_en;
    logic cross_bus;

    always_comb begin
        is_rd     = (evt_kind == XK_READ);
        is_pw     = (evt_kind == XK_PWRITE);
        is_dw     = (evt_kind == XK_DWRITE);
        both_en   = cfg_pri_perr_en & cfg_sec_perr_en;
        // own checker saw the error on the secondary side with response enabled
        sec_own   = evt_bus & evt_own_det & cfg_sec_perr_en;
        // another agent reported on the far (target) bus of the posted write
        cross_bus = evt_dir ? ~evt_bus : evt_bus;

        sperr_hit = evt_valid & (
                      (is_rd & ~evt_dir & sec_own)
                    | (is_pw &  evt_dir & sec_own)
                    | (is_dw &  evt_dir & (sec_own | (~evt_bus & evt_perr_seen & both_en))));

        serr_hit  = evt_valid & is_pw & evt_perr_seen & ~evt_own_det
                  & cross_bus & both_en & cfg_serr_en;
    end

endmodule

// File: rtl/perr_delay_line.sv
module perr_delay_line #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic line_n
);

    logic [DEPTH-1:0] stage_d, stage_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb stage_d = hit;
        end else begin : g_chain
            always_comb stage_d = {stage_q[DEPTH-2:0], hit};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign line_n = ~stage_q[DEPTH-1];

endmodule

// File: rtl/pci_bridge_err_reporter.sv
module pci_bridge_err_reporter
    import pci_perr_pkg::*;
#(
    parameter int SPERR_LAT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_valid,
    input  logic [1:0] evt_kind,
    input  logic       evt_dir,
    input  logic       evt_bus,
    input  logic       evt_own_det,
    input  logic       evt_perr_seen,
    input  logic       cfg_pri_perr_en,
    input  logic       cfg_sec_perr_en,
    input  logic       cfg_serr_en,
    input  logic       serr_clr,
    output logic       s_perr_n,
    output logic       p_serr_n,
    output logic       serr_status
);

    localparam int LAT_STAGES = (SPERR_LAT < 1) ? 1 : SPERR_LAT;

    logic       sperr_hit, serr_hit;
    top_state_t st_d, st_q;

    perr_event_decode u_dec (
        .evt_valid       (evt_valid),
        .evt_kind        (evt_kind),
        .evt_dir         (evt_dir),
        .evt_bus         (evt_bus),
        .evt_own_det     (evt_own_det),
        .evt_perr_seen   (evt_perr_seen),
        .cfg_pri_perr_en (cfg_pri_perr_en),
        .cfg_sec_perr_en (cfg_sec_perr_en),
        .cfg_serr_en     (cfg_serr_en),
        .sperr_hit       (sperr_hit),
        .serr_hit        (serr_hit)
    );

    perr_delay_line #(.DEPTH(LAT_STAGES)) u_sdly (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (sperr_hit),
        .line_n (s_perr_n)
    );

    always_comb begin
        st_d        = st_q;
        st_d.serr_n = ~serr_hit;
        // a new system error outranks a clear in the same cycle
        st_d.status = (st_q.status & ~serr_clr) | serr_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.serr_n <= 1'b1;
            st_q.status <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign p_serr_n    = st_q.serr_n;
    assign serr_status = st_q.status;

endmodule

// File: rtl/pci_perr_chk.sv
module pci_perr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_valid,
    input logic [1:0] evt_kind,
    input logic       evt_dir,
    input logic       cfg_pri_perr_en,
    input logic       cfg_sec_perr_en,
    input logic       cfg_serr_en,
    input logic       serr_clr,
    input logic       s_perr_n,
    input logic       p_serr_n,
    input logic       serr_status
);

    AST_SERR_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !p_serr_n |-> serr_status); // R10

    AST_STATUS_CLEAR_ONLY_BY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(serr_status) |-> $past(serr_clr)); // R10

    AST_READ_NO_SERR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_kind == 2'b00) |=> p_serr_n); // R9

    AST_SERR_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_pri_perr_en && cfg_sec_perr_en && cfg_serr_en) |=> p_serr_n); // R9

    AST_DS_DWRITE_NO_SPERR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_kind == 2'b10 && !evt_dir) |=> ##1 s_perr_n); // R6

    AST_SEC_EN_GATES_SPERR: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sec_perr_en |=> ##1 s_perr_n); // R7

    AST_IGNORED_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_valid || evt_kind == 2'b11) |=> (p_serr_n ##1 s_perr_n)); // R11

endmodule

bind pci_bridge_err_reporter pci_perr_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .evt_valid       (evt_valid),
    .evt_kind        (evt_kind),
    .evt_dir         (evt_dir),
    .cfg_pri_perr_en (cfg_pri_perr_en),
    .cfg_sec_perr_en (cfg_sec_perr_en),
    .cfg_serr_en     (cfg_serr_en),
    .serr_clr        (serr_clr),
    .s_perr_n        (s_perr_n),
    .p_serr_n        (p_serr_n),
    .serr_status     (serr_status)
);

// File: tb/sim_pci_bridge_err_reporter.sv
`timescale 1ns/1ps
module sim_pci_bridge_err_reporter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_valid = 1'b0;
    logic [1:0] evt_kind = 2'b00;
    logic       evt_dir = 1'b0, evt_bus = 1'b0, evt_own_det = 1'b0, evt_perr_seen = 1'b0;
    logic       cfg_pri_perr_en = 1'b0, cfg_sec_perr_en = 1'b0, cfg_serr_en = 1'b0;
    logic       serr_clr = 1'b0;
    logic       s_perr_n, p_serr_n, serr_status;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    // event word: {valid, kind[1:0], dir, bus, own, seen, pri_en, sec_en, serr_en, clr}
    logic [10:0] ev_p1 = '0, ev_p2 = '0;
    logic        stat_m = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pci_bridge_err_reporter u0 (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_dir(evt_dir), .evt_bus(evt_bus), .evt_own_det(evt_own_det),
        .evt_perr_seen(evt_perr_seen), .cfg_pri_perr_en(cfg_pri_perr_en),
        .cfg_sec_perr_en(cfg_sec_perr_en), .cfg_serr_en(cfg_serr_en),
        .serr_clr(serr_clr), .s_perr_n(s_perr_n), .p_serr_n(p_serr_n),
        .serr_status(serr_status)
    );

    function automatic bit exp_sperr(input logic [10:0] e);
        logic v = e[10]; logic [1:0] k = e[9:8]; logic d = e[7], b = e[6];
        logic own = e[5], seen = e[4], pe = e[3], se = e[2];
        bit sec_own = b & own & se;
        if (!v) return 0;
        case (k)
            2'b00:   return !d && sec_own;                                      // R3
            2'b01:   return d && sec_own;                                       // R4
            2'b10:   return d && (sec_own || (!b && seen && pe && se));         // R5 R6
            default: return 0;                                                  // R11
        endcase
    endfunction

    function automatic bit exp_serr(input logic [10:0] e);
        logic d = e[7], b = e[6];
        return e[10] && e[9:8] == 2'b01 && e[4] && !e[5] && (d != b)
               && e[3] && e[2] && e[1];                                         // R8 R9
    endfunction

    function automatic string tag_s(input logic [10:0] e);
        if (!e[10] || e[9:8] == 2'b11) return e[10] ? "R11" : "R2";
        if (!e[2]) return "R7";
        case (e[9:8])
            2'b00:   return "R3";
            2'b01:   return "R4";
            default: return e[7] ? "R5" : "R6";
        endcase
    endfunction

    function automatic string tag_p(input logic [10:0] e);
        return (e[10] && e[9:8] == 2'b01 && e[3] && e[2] && e[1]) ? "R8" : "R9";
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: check outputs due now, then drive the next event
    task automatic step(input logic [10:0] e);
        @(negedge clk);
        stat_m = (stat_m & ~ev_p1[0]) | exp_serr(ev_p1);
        chk(tag_s(ev_p2), s_perr_n, !exp_sperr(ev_p2));
        chk(tag_p(ev_p1), p_serr_n, !exp_serr(ev_p1));
        chk("R10", serr_status, stat_m);
        ev_p2 = ev_p1;
        ev_p1 = e;
        {evt_valid, evt_kind, evt_dir, evt_bus, evt_own_det, evt_perr_seen,
         cfg_pri_perr_en, cfg_sec_perr_en, cfg_serr_en, serr_clr} = e;
    endtask

    function automatic logic [10:0] mk(input logic v, input logic [1:0] k, input logic d,
        input logic b, input logic own, input logic seen, input logic pe,
        input logic se, input logic ee, input logic clr);
        return {v, k, d, b, own, seen, pe, se, ee, clr};
    endfunction

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk("R1", s_perr_n, 1'b1);
        chk("R1", p_serr_n, 1'b1);
        chk("R1", serr_status, 1'b0);
        rst_n = 1'b1;

        // directed corners
        step(mk(1, 2'b00, 0, 1, 1, 0, 1, 1, 1, 0));   // R3 hit, R2 isolated pulse
        step('0); step('0); step('0);
        step(mk(1, 2'b00, 0, 0, 1, 1, 1, 1, 1, 0));   // R3 primary: none
        step(mk(1, 2'b01, 1, 1, 1, 0, 1, 1, 1, 0));   // R4 upstream posted
        step(mk(1, 2'b01, 0, 1, 1, 0, 1, 1, 1, 0));   // R4 downstream posted: no S
        step(mk(1, 2'b10, 1, 0, 0, 1, 1, 1, 1, 0));   // R5 completion PERR#
        step(mk(1, 2'b10, 1, 0, 0, 1, 0, 1, 1, 0));   // R5 pri_en off: none
        step(mk(1, 2'b10, 0, 1, 1, 1, 1, 1, 1, 0));   // R6
        step(mk(1, 2'b00, 0, 1, 1, 0, 1, 0, 1, 0));   // R7
        step(mk(1, 2'b01, 1, 0, 0, 1, 1, 1, 1, 0));   // R8 upstream, primary PERR#
        step(mk(1, 2'b01, 0, 1, 0, 1, 1, 1, 1, 1));   // R8 + R10 clear collides with set
        step(mk(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, 1));   // R10 clear
        step(mk(1, 2'b01, 0, 1, 1, 1, 1, 1, 1, 0));   // R8 own-detect: none
        step(mk(1, 2'b01, 1, 0, 0, 1, 1, 1, 0, 0));   // R9 serr_en off
        step(mk(1, 2'b11, 1, 1, 1, 1, 1, 1, 1, 0));   // R11 reserved kind
        step(mk(0, 2'b01, 1, 0, 0, 1, 1, 1, 1, 0));   // R11 not valid

        for (int i = 0; i < 3000; i++) begin
            logic [10:0] e;
            e[10]  = ($urandom % 5) != 0;
            e[9:8] = 2'($urandom);
            e[7:4] = 4'($urandom);
            e[3]   = ($urandom % 4) != 0;
            e[2]   = ($urandom % 4) != 0;
            e[1]   = ($urandom % 4) != 0;
            e[0]   = ($urandom % 6) == 0;
            step(e);
        end
        step('0); step('0); step('0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule